// File: doc/BRIEF.md
# HDLC Receive Pool Buffer

This block sits behind an HDLC receiver's deframer and buffers the bytes it produces. The deframer presents one data byte at a time, and when it sees the closing flag it presents a close strobe. With that strobe come three qualifiers: whether the frame was a whole number of bytes long, whether the FCS matched, and whether the frame ended in an abort. The block stores the data bytes in a FIFO. At each close it appends one status byte that summarises the frame, so the frame and its outcome stay together in a single byte stream. The host drains that stream through a simple pop port.

Long frames are handed to the host in chunks of `POOL` stored bytes. A pool event marks each full chunk of a frame that is still open. A message-end event marks the final part of a frame, which includes its status byte, and a count register gives the size of that part. Data bytes that arrive when the FIFO is nearly full are dropped, and the frame's status records the loss. One slot is always kept back for the status byte. A frame whose close finds the FIFO completely full is dropped as a whole and reported by a separate frame-lost event.

Top module: `hdlc_rx_pool`

## Requirements
- R1: After reset the FIFO is empty (`rd_valid` low), no event is raised, and `part_count` is 0.
- R2: Stored bytes come out in arrival order. `rd_data` shows the oldest stored byte whenever `rd_valid` is high. A high `rd_en` at a clock edge removes that byte. The FIFO never holds more than `DEPTH` bytes.
- R3: In the cycle after `rx_close`, a status byte is stored behind the frame's data. Its bit 7 is `rx_whole`, bit 6 is set if any data byte of the frame was dropped, bit 5 is `rx_crc_ok`, bit 4 is `rx_abort`, and bits 3..0 are zero. A clean frame therefore gives 0xA0.
- R4: `pool_full` pulses for one cycle after the clock edge that stores the `POOL`-th byte of a chunk, when that byte is a data byte. Counting then restarts for the next chunk of the same frame.
- R5: `msg_end` pulses for one cycle after a close whose status byte is stored. In the same cycle `part_count` takes the number of bytes in the final chunk, status byte included, modulo `POOL` (a full chunk of `POOL` reads as 0).
- R6: `part_count` changes only in a cycle where `msg_end` is high.
- R7: A data byte that arrives while `DEPTH-1` or more bytes are stored is dropped. It does not count toward the chunk size, and it sets bit 6 of that frame's status byte.
- R8: If the FIFO holds `DEPTH` bytes when `rx_close` arrives, nothing is stored. `frame_lost` pulses for one cycle instead of `msg_end`, and the next frame starts with a clean state.
- R9: At most one of `pool_full`, `msg_end` and `frame_lost` is high in any cycle. Each `rx_close` is followed in the next cycle by exactly one of `msg_end` or `frame_lost`.
- R10: A high `rd_en` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte_valid | input | 1 | A deframed data byte is present this cycle |
| rx_byte | input | 8 | Deframed data byte |
| rx_close | input | 1 | Closing flag seen; the frame ends this cycle |
| rx_whole | input | 1 | With `rx_close`: frame length is a whole number of bytes |
| rx_crc_ok | input | 1 | With `rx_close`: FCS matched |
| rx_abort | input | 1 | With `rx_close`: frame was aborted |
| rd_en | input | 1 | Host pops the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| rd_valid | output | 1 | FIFO is not empty |
| pool_full | output | 1 | One-cycle pulse: a chunk of `POOL` bytes of an open frame is stored |
| msg_end | output | 1 | One-cycle pulse: final part of a frame, with its status byte, is stored |
| frame_lost | output | 1 | One-cycle pulse: a whole frame was lost for lack of space |
| part_count | output | $clog2(POOL) (5) | Byte count of the last final part, modulo `POOL` |

## Verification
The properties assume that the deframer never raises `rx_byte_valid` and `rx_close` in the same cycle. A close is always a separate beat after the last data byte. They also assume that the close qualifiers are only meaningful while `rx_close` is high. The stimulus sends every frame as a run of byte beats, sometimes with idle gaps, followed by a lone close beat, so the two strobes never overlap. Pops are requested at random, including while the FIFO is empty. Read rates are sometimes set to zero so that the near-full, dropped-byte and full-at-close paths are all reached.

// File: rtl/hdlc_rxp_pkg.sv
package hdlc_rxp_pkg;

    // Outcome flags that accompany the close strobe
    typedef struct packed {
        logic whole;
        logic crc_ok;
        logic aborted;
    } close_info_t;

    // Status byte layout: 7 whole, 6 data dropped, 5 FCS good, 4 aborted
    function automatic logic [7:0] make_status(input close_info_t info, input logic dropped);
        return {info.whole, dropped, info.crc_ok, info.aborted, 4'b0000};
    endfunction

endpackage

// File: rtl/rxp_store.sv
module rxp_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic [AW:0]   level
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } store_t;

    store_t st_d, st_q;
    logic   pop;
    logic [7:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        pop  = rd_en && (st_q.cnt != '0);
        if (wr_en) st_d.wp = st_q.wp + 1'b1;
        if (pop)   st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + (AW+1)'(wr_en) - (AW+1)'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Storage array carries no reset; occupancy guards every read
    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wp] <= wr_data;
    end

    assign rd_data  = mem[st_q.rp];
    assign rd_valid = (st_q.cnt != '0);
    assign level    = st_q.cnt;

endmodule

// File: rtl/rxp_frame_ctl.sv
module rxp_frame_ctl
    import hdlc_rxp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int POOL  = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(POOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          close,
    input  close_info_t   info,
    input  logic [AW:0]   level,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          pool_full,
    output logic          msg_end,
    output logic          frame_lost,
    output logic [CW-1:0] part_count
);

    localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW:0]   DATA_LIM = (AW+1)'(DEPTH - 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(POOL - 1);

    typedef struct packed {
        logic [CW-1:0] chunk;
        logic          dropped;
        logic          pool_ev;
        logic          end_ev;
        logic          lost_ev;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        c_d.pool_ev = 1'b0;
        c_d.end_ev  = 1'b0;
        c_d.lost_ev = 1'b0;
        wr_en       = 1'b0;
        wr_data     = byte_data;
        if (close) begin
            if (level < FULL_LVL) begin
                wr_en      = 1'b1;
                wr_data    = make_status(info, c_q.dropped);
                c_d.end_ev = 1'b1;
                c_d.cnt    = c_q.chunk + 1'b1;
            end else begin
                c_d.lost_ev = 1'b1;
            end
            c_d.chunk   = '0;
            c_d.dropped = 1'b0;
        end else if (byte_valid) begin
            if (level < DATA_LIM) begin
                wr_en = 1'b1;
                if (c_q.chunk == LAST_IDX) begin
                    c_d.pool_ev = 1'b1;
                    c_d.chunk   = '0;
                end else begin
                    c_d.chunk = c_q.chunk + 1'b1;
                end
            end else begin
                c_d.dropped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pool_full  = c_q.pool_ev;
    assign msg_end    = c_q.end_ev;
    assign frame_lost = c_q.lost_ev;
    assign part_count = c_q.cnt;

endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
    import hdlc_rxp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int POOL  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(POOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_byte_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_close,
    input  logic          rx_whole,
    input  logic          rx_crc_ok,
    input  logic          rx_abort,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          pool_full,
    output logic          msg_end,
    output logic          frame_lost,
    output logic [CW-1:0] part_count
);

    logic        wr_en;
    logic [7:0]  wr_data;
    logic [AW:0] fill_level;
    close_info_t info;

    assign info = '{whole: rx_whole, crc_ok: rx_crc_ok, aborted: rx_abort};

    rxp_frame_ctl #(.DEPTH(DEPTH), .POOL(POOL)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_byte_valid),
        .byte_data  (rx_byte),
        .close      (rx_close),
        .info       (info),
        .level      (fill_level),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pool_full  (pool_full),
        .msg_end    (msg_end),
        .frame_lost (frame_lost),
        .part_count (part_count)
    );

    rxp_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .level    (fill_level)
    );

endmodule

// File: rtl/hdlc_rx_pool_chk.sv
module hdlc_rx_pool_chk #(
    parameter int DEPTH = 64,
    parameter int POOL  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(POOL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_byte_valid,
    input logic          rx_close,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          pool_full,
    input logic          msg_end,
    input logic          frame_lost,
    input logic [CW-1:0] part_count,
    input logic [AW:0]   fill_level
);

    // R9 input side: byte beats and close beats never overlap
    input_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_byte_valid && rx_close));

    // R9
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pool_full, msg_end, frame_lost}));

    // R9
    close_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_close |=> (msg_end || frame_lost));

    // R8
    lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |-> $past(rx_close));

    // R4
    pool_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pool_full |-> $past(rx_byte_valid));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_end |-> $stable(part_count));

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= (AW+1)'(DEPTH));

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_en && !rx_byte_valid && !rx_close) |=> !rd_valid);

endmodule

bind hdlc_rx_pool hdlc_rx_pool_chk #(.DEPTH(DEPTH), .POOL(POOL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_byte_valid (rx_byte_valid),
    .rx_close      (rx_close),
    .rd_en         (rd_en),
    .rd_valid      (rd_valid),
    .pool_full     (pool_full),
    .msg_end       (msg_end),
    .frame_lost    (frame_lost),
    .part_count    (part_count),
    .fill_level    (fill_level)
);

// File: tb/hdlc_rx_pool_bench.sv
module hdlc_rx_pool_bench;

    localparam int DEPTH = 64;
    localparam int POOL  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_close = 1'b0;
    logic       rx_whole = 1'b0;
    logic       rx_crc_ok = 1'b0;
    logic       rx_abort = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       pool_full;
    logic       msg_end;
    logic       frame_lost;
    logic [4:0] part_count;

    hdlc_rx_pool #(.DEPTH(DEPTH), .POOL(POOL)) u_hdlc_rx_pool (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .rx_close(rx_close), .rx_whole(rx_whole),
        .rx_crc_ok(rx_crc_ok), .rx_abort(rx_abort),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .pool_full(pool_full), .msg_end(msg_end),
        .frame_lost(frame_lost), .part_count(part_count)
    );

    always #5 clk = ~clk;

    // Reference model state (bit 8 of a queued entry marks a status byte)
    int m_q[$];
    int m_chunk = 0;
    bit m_drop  = 0;
    int m_cnt   = 0;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic int status_of(input bit wh, input bit dr, input bit cr, input bit ab);
        return 256 | (int'(wh) << 7) | (int'(dr) << 6) | (int'(cr) << 5) | (int'(ab) << 4);
    endfunction

    // One clock of stimulus with model update and output comparison
    task automatic step(input bit bv, input bit [7:0] bd, input bit fe,
                        input bit wh, input bit cr, input bit ab, input bit rd);
        int sz;
        bit e_pool, e_msg, e_lost;
        @(negedge clk);
        rx_byte_valid = bv; rx_byte = bd; rx_close = fe;
        rx_whole = wh; rx_crc_ok = cr; rx_abort = ab; rd_en = rd;
        sz = m_q.size();
        chk(rd_valid == (sz > 0), (sz == 0) ? "R10 rd_valid" : "R2 rd_valid",
            int'(rd_valid), int'(sz > 0));
        if (rd && sz > 0)
            chk(rd_data == m_q[0][7:0], (m_q[0] > 255) ? "R3 status byte" : "R2 data order",
                int'(rd_data), m_q[0] & 255);
        @(posedge clk);
        e_pool = 0; e_msg = 0; e_lost = 0;
        if (rd && sz > 0) void'(m_q.pop_front());
        if (fe) begin
            if (sz < DEPTH) begin
                m_q.push_back(status_of(wh, m_drop, cr, ab));
                e_msg = 1;
                m_cnt = (m_chunk + 1) % POOL;
            end else begin
                e_lost = 1;
            end
            m_chunk = 0; m_drop = 0;
        end else if (bv) begin
            if (sz < DEPTH - 1) begin
                m_q.push_back(int'(bd));
                m_chunk++;
                if (m_chunk == POOL) begin e_pool = 1; m_chunk = 0; end
            end else begin
                m_drop = 1;
            end
        end
        #1;
        chk(pool_full == e_pool, "R4 pool_full", int'(pool_full), int'(e_pool));
        chk(msg_end == e_msg, "R5 msg_end", int'(msg_end), int'(e_msg));
        chk(frame_lost == e_lost, "R8 frame_lost", int'(frame_lost), int'(e_lost));
        chk(int'(part_count) == m_cnt, e_msg ? "R5 part_count" : "R6 part_count",
            int'(part_count), m_cnt);
    endtask

    task automatic send_frame(input int len, input bit wh, input bit cr, input bit ab,
                              input int rd_pct, input int gap_pct);
        for (int i = 0; i < len; i++) begin
            if ($urandom_range(0, 99) < gap_pct)
                step(0, 8'h00, 0, 0, 0, 0, $urandom_range(0, 99) < rd_pct);
            step(1, 8'($urandom), 0, 0, 0, 0, $urandom_range(0, 99) < rd_pct);
        end
        step(0, 8'h00, 1, wh, cr, ab, $urandom_range(0, 99) < rd_pct);
    endtask

    task automatic drain(output int popped);
        popped = 0;
        while (m_q.size() > 0) begin
            step(0, 8'h00, 0, 0, 0, 0, 1);
            popped++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        n_fail++;
        n_checks++;
        finish_run();
    end

    initial begin
        int popped;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(rd_valid == 1'b0, "R1 empty", int'(rd_valid), 0);
        chk({pool_full, msg_end, frame_lost} == 3'b000, "R1 events",
            int'({pool_full, msg_end, frame_lost}), 0);
        chk(part_count == 5'd0, "R1 part_count", int'(part_count), 0);

        // R10 pop while empty, then a short clean frame: status 0xA0, count 4 (R3, R5)
        step(0, 8'h00, 0, 0, 0, 0, 1);
        send_frame(3, 1, 1, 0, 0, 0);
        drain(popped);
        chk(popped == 4, "R3 short frame bytes", popped, 4);

        // R4: exactly POOL data bytes give a pool event, then status alone, count 1
        send_frame(32, 1, 1, 0, 0, 0);
        drain(popped);
        // R5: POOL-1 data bytes plus status fill a chunk, count reads 0
        send_frame(31, 0, 0, 1, 0, 0);
        drain(popped);

        // R7: no reads, long frame overruns; status still stored with bit 6 set
        send_frame(70, 1, 1, 0, 0, 0);
        chk(m_q.size() == DEPTH, "R7 fill with reserved status slot", m_q.size(), DEPTH);
        // R8: FIFO full at close, whole frame lost
        send_frame(2, 1, 1, 0, 0, 0);
        drain(popped);
        chk(popped == DEPTH, "R7 stored bytes after overrun", popped, DEPTH);
        // R10: pops on an empty FIFO leave it empty
        step(0, 8'h00, 0, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0, 0, 1);

        // Random phase: mixed lengths, outcomes and read rates
        for (int f = 0; f < 80; f++) begin
            int rp;
            rp = (f % 7 == 3) ? 0 : int'($urandom_range(10, 90));
            send_frame($urandom_range(0, 75), 1'($urandom), 1'($urandom), 1'($urandom),
                       rp, $urandom_range(0, 30));
            if (f % 10 == 9) drain(popped);
        end
        drain(popped);
        finish_run();
    end

endmodule